// File: doc/BRIEF.md
# Burst-Tolerant Processor Register File

This block is a 32-entry, 32-bit register file with two asynchronous read ports and one synchronous write port. It guards every stored value against single and adjacent multi-bit upsets by choosing a protection method per value at write time. A value whose upper half is all zero is treated as short. Its low half is mirrored into the upper half of the same entry. Any other value is long and gets a copy in a small shared pool of backup entries, which all architectural registers compete for.

Each entry carries eight parity bits: four interleaved groups for each half. A read checks the primary entry. Where a parity field fails, the bits of that field are taken from the other copy. That copy is the other half for a short value and the backup entry for a long value. The corrected word appears on the port together with an error flag. At the same clock edge the good value is written back into the primary entry.

When neither copy of a field is clean, or a long value has lost its backup, the port raises an uncorrectable flag and shows the raw stored word. A simple injection port flips chosen data bits in a primary or backup entry without touching its parity, so that upsets can be produced at will.

Top module: `hardened_regfile`

## Requirements
- R1: A write (wr_en=1) stores wr_data into register wr_addr at the rising edge. From the next cycle, a read of that register returns wr_data with both flags low. Reads are combinational, so a read of the register being written in the same cycle still returns the old value.
- R2: A value is short exactly when bits 31:16 are all zero. Its low half is stored twice, and a read returns it zero-extended (equal to the written value). Writing a short value releases any backup entry owned by that register.
- R3: Parity field k = (i/16)*4 + (i mod 4) covers data bit i with even parity. For a short value, any error confined to 4 consecutive bits of the 32-bit entry is corrected: err=1, unc=0, and the data equals the written value.
- R4: For a long value that owns a backup entry, any error confined to 4 consecutive bits of the primary entry is corrected from the backup: err=1, unc=0, and the data equals the written value.
- R5: A long write reuses the backup entry the register already owns. Otherwise it takes the lowest-numbered free entry. With all 8 entries in use it evicts the entry at a victim pointer, which starts at 0, advances by one after each eviction and wraps from 7 to 0. The evicted register is left unprotected.
- R6: The port raises err=1 and unc=1 and returns the raw stored word in two cases. The first is a parity field that fails in both copies. The second is an error on a long value with no backup entry. For a short value the raw word holds both halves.
- R7: A corrected read (err=1, unc=0) writes the good value back into the primary entry at the edge that ends that cycle, so the next read of that register shows err=0. When both ports need a write-back, port A wins and port B's register is repaired one cycle later. Uncorrectable reads are not written back.
- R8: A write to the register being repaired in the same cycle takes priority over the write-back. A write to a different register happens alongside the write-back.
- R9: With inj_en=1 and inj_bk=0, inj_mask is XORed into the data of primary register inj_addr. With inj_bk=1 it is XORed into backup entry inj_addr[2:0]. Parity bits are left unchanged in both cases.
- R10: After reset every register reads zero with both flags low, the backup pool is empty and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write value |
| ra_addr | input | 5 | Read port A register index |
| ra_data | output | 32 | Read port A value (corrected or raw) |
| ra_err | output | 1 | Read port A parity error seen |
| ra_unc | output | 1 | Read port A error could not be corrected |
| rb_addr | input | 5 | Read port B register index |
| rb_data | output | 32 | Read port B value (corrected or raw) |
| rb_err | output | 1 | Read port B parity error seen |
| rb_unc | output | 1 | Read port B error could not be corrected |
| inj_en | input | 1 | Bit-flip injection enable |
| inj_bk | input | 1 | Injection target: 0 primary register, 1 backup entry |
| inj_addr | input | 5 | Injection register index, or backup index in the low 3 bits |
| inj_mask | input | 32 | Data bits to flip |

## Verification
A write-back of a corrected read and an ordinary write can land in the same clock edge. They can target the same register or two different ones. The bench corrupts a register while both ports are parked on a clean entry. In the cycle the corrupted register is first read, it also drives a write to that register with a new value. The result counts as correct only if the next cycle shows the new value, not the repaired old one, with no error. A second case pairs a two-port repair with a write elsewhere. The bench then confirms that port B is repaired one cycle after port A and that the unrelated write landed.

// File: rtl/hrf_pkg.sv
`timescale 1ns/1ps
package hrf_pkg;
  // number of interleaved parity groups in each half of an entry
  localparam int unsigned HRF_GROUPS = 4;

  // parity field that holds data bit i: half index times groups plus bit modulo groups
  function automatic int field_of(input int i, input int half, input int ng);
    return (i / half) * ng + (i % ng);
  endfunction
endpackage

// File: rtl/hrf_parity_gen.sv
`timescale 1ns/1ps
module hrf_parity_gen #(
  parameter int W  = 32,
  parameter int NG = 4,
  localparam int PW  = 2 * NG,
  localparam int PIW = $clog2(PW)
) (
  input  logic [W-1:0]  d,
  output logic [PW-1:0] p
);
  localparam int HALF = W / 2;

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      p[PIW'(hrf_pkg::field_of(i, HALF, NG))] ^= d[i];
    end
  end
endmodule

// File: rtl/hrf_read_path.sv
`timescale 1ns/1ps
module hrf_read_path #(
  parameter int W  = 32,
  parameter int NG = 4,
  localparam int PW  = 2 * NG,
  localparam int PIW = $clog2(PW)
) (
  input  logic [W-1:0]  prim_d,
  input  logic [PW-1:0] prim_p,
  input  logic          prim_short,
  input  logic          bk_hit,
  input  logic [W-1:0]  bk_d,
  input  logic [PW-1:0] bk_p,
  output logic [W-1:0]  rd_d,
  output logic          err,
  output logic          unc,
  output logic [W-1:0]  fix_d
);
  localparam int HALF = W / 2;

  logic [PW-1:0] prim_calc, bk_calc;
  logic [PW-1:0] prim_ok, bk_ok;
  logic [HALF-1:0] lo_fix;
  logic [W-1:0]    long_fix;
  logic            bad;

  hrf_parity_gen #(.W(W), .NG(NG)) u_pchk (.d(prim_d), .p(prim_calc));
  hrf_parity_gen #(.W(W), .NG(NG)) u_bchk (.d(bk_d),   .p(bk_calc));

  assign prim_ok = ~(prim_calc ^ prim_p);
  assign bk_ok   = ~(bk_calc ^ bk_p) & {PW{bk_hit}};

  always_comb begin
    lo_fix   = '0;
    long_fix = '0;
    bad      = 1'b0;
    if (prim_short) begin
      for (int j = 0; j < HALF; j++) begin
        if (prim_ok[PIW'(j % NG)])
          lo_fix[j] = prim_d[j];
        else if (prim_ok[PIW'(NG + (j % NG))])
          lo_fix[j] = prim_d[HALF + j];
        else
          bad = 1'b1;
      end
    end else begin
      for (int i = 0; i < W; i++) begin
        if (prim_ok[PIW'(hrf_pkg::field_of(i, HALF, NG))])
          long_fix[i] = prim_d[i];
        else if (bk_ok[PIW'(hrf_pkg::field_of(i, HALF, NG))])
          long_fix[i] = bk_d[i];
        else
          bad = 1'b1;
      end
    end
  end

  assign err   = ~&prim_ok;
  assign unc   = bad;
  assign fix_d = prim_short ? {lo_fix, lo_fix} : long_fix;
  assign rd_d  = bad ? prim_d : (prim_short ? {{HALF{1'b0}}, lo_fix} : long_fix);
endmodule

// File: rtl/hrf_backup_pool.sv
`timescale 1ns/1ps
module hrf_backup_pool #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int NBK  = 8,
  parameter int PW   = 8,
  parameter int NRP  = 2,
  localparam int AW = $clog2(NREG),
  localparam int BW = $clog2(NBK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic           wr_long,
  input  logic [W-1:0]   wr_d,
  input  logic [PW-1:0]  wr_p,
  input  logic           inj_en,
  input  logic [BW-1:0]  inj_idx,
  input  logic [W-1:0]   inj_mask,
  input  logic [AW-1:0]  lk_addr  [NRP],
  output logic           lk_hit   [NRP],
  output logic [W-1:0]   lk_d     [NRP],
  output logic [PW-1:0]  lk_p     [NRP],
  output logic [NBK-1:0] lk_match [NRP]
);
  logic [W-1:0]  bdat [NBK];
  logic [PW-1:0] bpar [NBK];
  logic [AW-1:0] bown [NBK];
  logic [NBK-1:0] bvld;
  logic [BW-1:0]  victim;

  logic [NBK-1:0] own_hit;
  logic [BW-1:0]  own_idx, free_idx, tgt;
  logic           free_any, evict;

  always_comb begin
    for (int e = 0; e < NBK; e++) own_hit[e] = bvld[e] && (bown[e] == wr_addr);
  end

  always_comb begin
    own_idx  = '0;
    free_idx = '0;
    free_any = 1'b0;
    for (int e = NBK - 1; e >= 0; e--) begin
      if (own_hit[e]) own_idx = BW'(e);
      if (!bvld[e]) begin
        free_idx = BW'(e);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    tgt   = victim;
    evict = 1'b0;
    if (|own_hit)      tgt = own_idx;
    else if (free_any) tgt = free_idx;
    else               evict = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NBK; e++) begin
        bdat[e] <= '0;
        bpar[e] <= '0;
        bown[e] <= '0;
      end
      bvld   <= '0;
      victim <= '0;
    end else begin
      if (inj_en) bdat[inj_idx] <= bdat[inj_idx] ^ inj_mask;
      if (wr_en) begin
        if (wr_long) begin
          bdat[tgt] <= wr_d;
          bpar[tgt] <= wr_p;
          bown[tgt] <= wr_addr;
          bvld[tgt] <= 1'b1;
          if (evict) victim <= (victim == BW'(NBK - 1)) ? '0 : victim + 1'b1;
        end else begin
          for (int e = 0; e < NBK; e++) if (own_hit[e]) bvld[e] <= 1'b0;
        end
      end
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_look
    always_comb begin
      lk_d[p] = '0;
      lk_p[p] = '0;
      for (int e = 0; e < NBK; e++) begin
        lk_match[p][e] = bvld[e] && (bown[e] == lk_addr[p]);
        if (lk_match[p][e]) begin
          lk_d[p] = lk_d[p] | bdat[e];
          lk_p[p] = lk_p[p] | bpar[e];
        end
      end
    end
    assign lk_hit[p] = |lk_match[p];
  end
endmodule

// File: rtl/hardened_regfile.sv
`timescale 1ns/1ps
module hardened_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int NBK  = 8,
  localparam int AW = $clog2(NREG),
  localparam int BW = $clog2(NBK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  output logic          ra_err,
  output logic          ra_unc,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  output logic          rb_err,
  output logic          rb_unc,
  input  logic          inj_en,
  input  logic          inj_bk,
  input  logic [AW-1:0] inj_addr,
  input  logic [W-1:0]  inj_mask
);
  localparam int NG   = hrf_pkg::HRF_GROUPS;
  localparam int PW   = 2 * NG;
  localparam int HALF = W / 2;
  localparam int NRP  = 2;

  logic [W-1:0]    pdat   [NREG];
  logic [PW-1:0]   ppar   [NREG];
  logic [NREG-1:0] pshort;

  // write path classification and parity
  logic          wr_short;
  logic [W-1:0]  wr_store;
  logic [PW-1:0] wr_par;

  assign wr_short = ~|wr_data[W-1:HALF];
  assign wr_store = wr_short ? {wr_data[HALF-1:0], wr_data[HALF-1:0]} : wr_data;

  hrf_parity_gen #(.W(W), .NG(NG)) u_wpar (.d(wr_store), .p(wr_par));

  // read ports
  logic [AW-1:0]  rd_addr  [NRP];
  logic           bk_hit   [NRP];
  logic [W-1:0]   bk_d     [NRP];
  logic [PW-1:0]  bk_p     [NRP];
  logic [NBK-1:0] bk_match [NRP];
  logic [W-1:0]   rd_d     [NRP];
  logic           rd_err   [NRP];
  logic           rd_unc   [NRP];
  logic [W-1:0]   rd_fix   [NRP];

  assign rd_addr[0] = ra_addr;
  assign rd_addr[1] = rb_addr;

  hrf_backup_pool #(.NREG(NREG), .W(W), .NBK(NBK), .PW(PW), .NRP(NRP)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_long  (~wr_short),
    .wr_d     (wr_store),
    .wr_p     (wr_par),
    .inj_en   (inj_en & inj_bk),
    .inj_idx  (inj_addr[BW-1:0]),
    .inj_mask (inj_mask),
    .lk_addr  (rd_addr),
    .lk_hit   (bk_hit),
    .lk_d     (bk_d),
    .lk_p     (bk_p),
    .lk_match (bk_match)
  );

  for (genvar p = 0; p < NRP; p++) begin : g_port
    hrf_read_path #(.W(W), .NG(NG)) u_rd (
      .prim_d     (pdat[rd_addr[p]]),
      .prim_p     (ppar[rd_addr[p]]),
      .prim_short (pshort[rd_addr[p]]),
      .bk_hit     (bk_hit[p]),
      .bk_d       (bk_d[p]),
      .bk_p       (bk_p[p]),
      .rd_d       (rd_d[p]),
      .err        (rd_err[p]),
      .unc        (rd_unc[p]),
      .fix_d      (rd_fix[p])
    );
  end

  assign ra_data = rd_d[0];
  assign ra_err  = rd_err[0];
  assign ra_unc  = rd_unc[0];
  assign rb_data = rd_d[1];
  assign rb_err  = rd_err[1];
  assign rb_unc  = rd_unc[1];

  // write-back of corrected reads, port A first
  logic          sc_req_a, sc_req_b, sc_go;
  logic [AW-1:0] sc_addr;
  logic [W-1:0]  sc_val;
  logic [PW-1:0] sc_par;

  assign sc_req_a = rd_err[0] & ~rd_unc[0];
  assign sc_req_b = rd_err[1] & ~rd_unc[1];
  assign sc_addr  = sc_req_a ? ra_addr : rb_addr;
  assign sc_val   = sc_req_a ? rd_fix[0] : rd_fix[1];
  assign sc_go    = (sc_req_a | sc_req_b) & ~(wr_en && (wr_addr == sc_addr));

  hrf_parity_gen #(.W(W), .NG(NG)) u_spar (.d(sc_val), .p(sc_par));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        pdat[r] <= '0;
        ppar[r] <= '0;
      end
      pshort <= '1;
    end else begin
      if (sc_go) begin
        pdat[sc_addr] <= sc_val;
        ppar[sc_addr] <= sc_par;
      end
      if (inj_en && !inj_bk) pdat[inj_addr] <= pdat[inj_addr] ^ inj_mask;
      if (wr_en) begin
        pdat[wr_addr]   <= wr_store;
        ppar[wr_addr]   <= wr_par;
        pshort[wr_addr] <= wr_short;
      end
    end
  end
endmodule

// File: rtl/hrf_checker.sv
`timescale 1ns/1ps
module hrf_checker #(
  parameter int AW  = 5,
  parameter int W   = 32,
  parameter int NBK = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [W-1:0]   wr_data,
  input logic           inj_en,
  input logic [AW-1:0]  ra_addr,
  input logic [W-1:0]   ra_data,
  input logic           ra_err,
  input logic           ra_unc,
  input logic           rb_err,
  input logic           rb_unc,
  input logic           sc_go,
  input logic [NBK-1:0] match_a,
  input logic [NBK-1:0] match_b
);
  // R6: an uncorrectable flag always comes with the error flag
  assert_unc_has_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_unc |-> ra_err) and (rb_unc |-> rb_err));

  // R1: a clean write reads back unchanged on the next cycle
  assert_write_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inj_en) |=>
      ((ra_addr != $past(wr_addr)) || (ra_data == $past(wr_data) && !ra_err)));

  // R7: a corrected read with no competing write or injection is clean one cycle later
  assert_repair_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_err && !ra_unc && !(wr_en && wr_addr == ra_addr) && !inj_en) |=>
      ((ra_addr != $past(ra_addr)) || (!ra_err && ra_data == $past(ra_data))));

  // R5: at most one backup entry belongs to any register
  assert_owner_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_a) && $onehot0(match_b));

  // R8: a write-back never happens while no port reports a correctable error
  assert_repair_needs_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_go |-> ((ra_err && !ra_unc) || (rb_err && !rb_unc)));
endmodule

bind hardened_regfile hrf_checker #(.AW(AW), .W(W), .NBK(NBK)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .inj_en  (inj_en),
  .ra_addr (ra_addr),
  .ra_data (ra_data),
  .ra_err  (ra_err),
  .ra_unc  (ra_unc),
  .rb_err  (rb_err),
  .rb_unc  (rb_unc),
  .sc_go   (sc_go),
  .match_a (bk_match[0]),
  .match_b (bk_match[1])
);

// File: tb/test_hardened_regfile.sv
`timescale 1ns/1ps
module test_hardened_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  ra_addr = '0;
  logic [31:0] ra_data;
  logic        ra_err, ra_unc;
  logic [4:0]  rb_addr = '0;
  logic [31:0] rb_data;
  logic        rb_err, rb_unc;
  logic        inj_en = 1'b0;
  logic        inj_bk = 1'b0;
  logic [4:0]  inj_addr = '0;
  logic [31:0] inj_mask = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  hardened_regfile i_hardened_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ra_addr(ra_addr), .ra_data(ra_data), .ra_err(ra_err), .ra_unc(ra_unc),
    .rb_addr(rb_addr), .rb_data(rb_data), .rb_err(rb_err), .rb_unc(rb_unc),
    .inj_en(inj_en), .inj_bk(inj_bk), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  // {register, value}; values with zero upper half are short, others long
  localparam logic [36:0] VEC [8] = '{
    {5'd1,  32'h0000_0000}, {5'd2,  32'h0000_FFFF},
    {5'd4,  32'h0001_0000}, {5'd6,  32'hFFFF_FFFF},
    {5'd7,  32'h0000_7A5C}, {5'd8,  32'h8000_0000},
    {5'd9,  32'h1234_5678}, {5'd10, 32'h0000_8001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic inj(input logic bk, input logic [4:0] a, input logic [31:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_bk = bk; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic park();
    ra_addr = 5'd0; rb_addr = 5'd0;
  endtask

  task automatic see_a(input string tag, input logic [31:0] d, input logic e, input logic u);
    #1;
    chk({tag, " data"}, ra_data, d);
    chk({tag, " err"}, {31'd0, ra_err}, {31'd0, e});
    chk({tag, " unc"}, {31'd0, ra_unc}, {31'd0, u});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    ra_addr = 5'd0; rb_addr = 5'd31;
    see_a("R10 reset r0", 32'h0, 1'b0, 1'b0);
    chk("R10 reset r31 data", rb_data, 32'h0);
    chk("R10 reset r31 err", {31'd0, rb_err}, 32'h0);

    // R1 R2: table of writes read back on both ports
    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][36:32], VEC[v][31:0]);
      ra_addr = VEC[v][36:32]; rb_addr = VEC[v][36:32];
      see_a("R1 R2 table port A", VEC[v][31:0], 1'b0, 1'b0);
      chk("R1 table port B", rb_data, VEC[v][31:0]);
    end

    // R3 R9: short value, burst in the lower copy
    park();
    wr(5'd3, 32'h0000_1234);
    inj(1'b0, 5'd3, 32'h0000_F000);
    ra_addr = 5'd3;
    see_a("R3 R9 short low burst", 32'h0000_1234, 1'b1, 1'b0);
    @(negedge clk);
    see_a("R7 short repaired", 32'h0000_1234, 1'b0, 1'b0);

    // R3: burst straddling the two halves
    park();
    inj(1'b0, 5'd3, 32'h0003_C000);
    ra_addr = 5'd3;
    see_a("R3 short straddle burst", 32'h0000_1234, 1'b1, 1'b0);
    @(negedge clk);

    // R6: same group bad in both copies
    park();
    inj(1'b0, 5'd3, 32'h0001_0001);
    ra_addr = 5'd3;
    see_a("R6 short both copies", 32'h1235_1235, 1'b1, 1'b1);
    @(negedge clk);
    see_a("R7 unc not repaired", 32'h1235_1235, 1'b1, 1'b1);
    park();
    wr(5'd3, 32'h0000_1234);

    // R4: long value with backup (r4,r6,r8,r9 hold entries 0..3, r5 takes entry 4)
    wr(5'd5, 32'hDEAD_BEEF);
    inj(1'b0, 5'd5, 32'h0000_0F00);
    ra_addr = 5'd5;
    see_a("R4 long burst", 32'hDEAD_BEEF, 1'b1, 1'b0);
    @(negedge clk);
    see_a("R7 long repaired", 32'hDEAD_BEEF, 1'b0, 1'b0);

    // R6 R9: primary and backup bad in the same field
    park();
    inj(1'b1, 5'd4, 32'h0000_0001);
    inj(1'b0, 5'd5, 32'h0000_0001);
    ra_addr = 5'd5;
    see_a("R6 R9 long both copies", 32'hDEAD_BEEE, 1'b1, 1'b1);
    park();
    wr(5'd5, 32'hDEAD_BEEF);

    // R5: fill the pool, then evict entry 0 (owner r4)
    wr(5'd11, 32'h1111_0000);
    wr(5'd12, 32'h2222_0000);
    wr(5'd13, 32'h3333_0000);
    wr(5'd14, 32'h4444_0000);
    inj(1'b0, 5'd4, 32'h0000_0008);
    ra_addr = 5'd4;
    see_a("R5 R6 evicted unprotected", 32'h0001_0008, 1'b1, 1'b1);
    park();
    wr(5'd4, 32'h0000_0000);

    // R2 R5: short write frees entry 3, next long takes it without eviction
    wr(5'd9, 32'h0000_0055);
    ra_addr = 5'd9;
    see_a("R2 short rewrite", 32'h0000_0055, 1'b0, 1'b0);
    park();
    wr(5'd15, 32'hCAFE_0000);
    inj(1'b0, 5'd6, 32'h0000_00F0);
    ra_addr = 5'd6;
    see_a("R5 free entry used, r6 kept", 32'hFFFF_FFFF, 1'b1, 1'b0);
    @(negedge clk);
    park();
    inj(1'b0, 5'd15, 32'h0000_000F);
    ra_addr = 5'd15;
    see_a("R5 r15 protected", 32'hCAFE_0000, 1'b1, 1'b0);
    @(negedge clk);

    // R5: pool full again, victim pointer now at entry 1 (r6)
    park();
    wr(5'd16, 32'h5555_0000);
    inj(1'b0, 5'd6, 32'h0000_0001);
    ra_addr = 5'd6;
    see_a("R5 victim advanced", 32'hFFFF_FFFE, 1'b1, 1'b1);
    park();
    inj(1'b0, 5'd8, 32'h0000_0001);
    ra_addr = 5'd8;
    see_a("R5 entry 2 kept", 32'h8000_0000, 1'b1, 1'b0);
    @(negedge clk);

    // R8: write to the register under repair wins
    park();
    inj(1'b0, 5'd3, 32'h0000_000F);
    ra_addr = 5'd3;
    wr_en = 1'b1; wr_addr = 5'd3; wr_data = 32'h0000_00AB;
    see_a("R8 repair cycle", 32'h0000_1234, 1'b1, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    see_a("R8 write beats repair", 32'h0000_00AB, 1'b0, 1'b0);

    // R7 R8: two ports faulty, A first; unrelated write in the same cycle
    park();
    inj(1'b0, 5'd2, 32'h0000_0001);
    inj(1'b0, 5'd7, 32'h0001_0000);
    ra_addr = 5'd2; rb_addr = 5'd7;
    wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h0000_0777;
    see_a("R7 dual A", 32'h0000_FFFF, 1'b1, 1'b0);
    chk("R7 dual B data", rb_data, 32'h0000_7A5C);
    chk("R7 dual B err", {31'd0, rb_err}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    see_a("R7 A repaired first", 32'h0000_FFFF, 1'b0, 1'b0);
    chk("R7 B still pending", {31'd0, rb_err}, 32'd1);
    @(negedge clk);
    #1;
    chk("R7 B repaired next", {31'd0, rb_err}, 32'd0);
    chk("R7 B data", rb_data, 32'h0000_7A5C);
    ra_addr = 5'd20;
    see_a("R8 side write landed", 32'h0000_0777, 1'b0, 1'b0);

    // R1: read during write returns old value
    @(negedge clk);
    ra_addr = 5'd21;
    wr_en = 1'b1; wr_addr = 5'd21; wr_data = 32'h0000_0099;
    see_a("R1 read during write", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    see_a("R1 after write", 32'h0000_0099, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule